// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block sits beside a processor pipeline and decides which pending exception the core enters next. Six request sources reach it: a reset request, a data abort, a fast interrupt, a normal interrupt, a prefetch abort and a software interrupt. The fast and normal interrupt lines are asynchronous, so each passes through a flop synchronizer before arbitration. The other four are synchronous to the core clock. The block applies the core's two interrupt mask bits and picks one winner by fixed rank. It admits that winner only at an instruction boundary, which the pipeline-ready strobe marks. A reset request is the exception to this rule and is always admitted.

On entry the block emits a one-cycle take pulse. With it come the exception ID, which also serves as the vector index, and the handler mode. It also gives the return-address adjustment the handler subtracts from the saved link, the saved link value itself (the PC presented in the decision cycle) and the updated mask bits. Entering the fast interrupt raises both masks, so a normal interrupt cannot preempt the fast handler. The fast handler keeps its own banked state, so no context save is needed for it.

A small state machine controls entry. **BOOT** is the reset state. The transition *boot_entry* (BOOT→HOLD) always emits a reset exception. **RUN** arbitrates. The transition *enter* (RUN→HOLD) is taken when a winner exists and either the pipeline is ready or the winner is reset. The transition *wait* (RUN→RUN) is taken otherwise. **HOLD** is one idle cycle that lets the core apply the new masks. The transition *resume* (HOLD→RUN) always follows.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The ranking, highest first, is reset (ID 0), data abort (ID 1), fast interrupt (ID 2), normal interrupt (ID 3), prefetch abort (ID 4) and software interrupt (ID 5). `exc_id_o` carries the winner's ID on `take_o`.
- R2: After `rst_n` is released, the first clock edge produces a take with ID 0 and both mask outputs at 1. No request is needed for this.
- R3: `req_rst` is admitted even while `pipe_ready` is 0. Its entry drives both `mask_f_o` and `mask_i_o` to 1.
- R4: Every other request is admitted only in a cycle where `pipe_ready` is 1.
- R5: The fast interrupt is ignored while `mask_f_in` is 1. The normal interrupt is ignored while `mask_i_in` is 1.
- R6: Every entry sets `mask_i_o` to 1. `mask_f_o` becomes 1 on reset and fast-interrupt entry. For all other entries it equals `mask_f_in` of the decision cycle.
- R7: `ret_adj_o` is 4 for the fast interrupt, the normal interrupt and the prefetch abort. It is 8 for the data abort and 0 for the software interrupt and reset.
- R8: `link_o` on a take equals `cur_pc` of the decision cycle, which is the cycle before the pulse.
- R9: `mode_o` on a take is 0 (supervisor) for reset and the software interrupt, 1 (abort) for both aborts, 2 for the fast interrupt and 3 for the normal interrupt.
- R10: An asynchronous interrupt line raised before clock edge k produces its take after edge k+SYNC_STAGES, and not earlier.
- R11: `take_o` is a single-cycle pulse and is always followed by at least one cycle without a take.
- R12: Outside a take, `mask_f_o` and `mask_i_o` repeat the mask inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_rst | input | 1 | Synchronous reset request |
| req_dabt | input | 1 | Data abort request |
| fiq_async | input | 1 | Fast interrupt line, asynchronous |
| irq_async | input | 1 | Normal interrupt line, asynchronous |
| req_pabt | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| mask_f_in | input | 1 | Current fast-interrupt mask |
| mask_i_in | input | 1 | Current normal-interrupt mask |
| pipe_ready | input | 1 | Instruction boundary strobe |
| cur_pc | input | ADDR_W | PC presented in the decision cycle |
| take_o | output | 1 | One-cycle exception entry pulse |
| exc_id_o | output | 3 | Exception ID / vector index |
| mode_o | output | 2 | Handler mode |
| ret_adj_o | output | 4 | Return adjustment subtracted from the link |
| link_o | output | ADDR_W | Saved link value |
| mask_f_o | output | 1 | Updated fast-interrupt mask |
| mask_i_o | output | 1 | Updated normal-interrupt mask |

## Verification
The two functions that can meet in one cycle are synchronous fault entry and asynchronous interrupt entry. A data abort and an already synchronized fast interrupt can both be pending in the same decision cycle. The bench provokes this by holding `pipe_ready` low while the fast interrupt settles through the synchronizer, then raising the data abort and `pipe_ready` together. Correct behaviour is a data-abort take that leaves `mask_f_o` clear, then one idle cycle, then the fast-interrupt take with both masks set.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int N_EXC = 6;
    localparam int ID_W  = 3;

    typedef enum logic [2:0] {
        EXC_RST  = 3'd0,
        EXC_DABT = 3'd1,
        EXC_FIQ  = 3'd2,
        EXC_IRQ  = 3'd3,
        EXC_PABT = 3'd4,
        EXC_SWI  = 3'd5
    } exc_id_t;

    typedef enum logic [1:0] {
        MODE_SVC = 2'd0,
        MODE_ABT = 2'd1,
        MODE_FIQ = 2'd2,
        MODE_IRQ = 2'd3
    } exc_mode_t;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } ctl_state_t;

    function automatic exc_mode_t mode_of(exc_id_t id);
        unique case (id)
            EXC_DABT, EXC_PABT: mode_of = MODE_ABT;
            EXC_FIQ:            mode_of = MODE_FIQ;
            EXC_IRQ:            mode_of = MODE_IRQ;
            default:            mode_of = MODE_SVC;
        endcase
    endfunction

    function automatic logic [3:0] adj_of(exc_id_t id);
        unique case (id)
            EXC_FIQ, EXC_IRQ, EXC_PABT: adj_of = 4'd4;
            EXC_DABT:                   adj_of = 4'd8;
            default:                    adj_of = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int N = N_EXC
) (
    input  logic [N-1:0] req_i,
    output logic         hit_o,
    output exc_id_t      win_o
);
    always_comb begin
        hit_o = |req_i;
        win_o = EXC_SWI;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) win_o = exc_id_t'(i[ID_W-1:0]);
        end
    end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit_i,
    input  exc_id_t win_i,
    input  logic    ready_i,
    output logic    go_o,
    output exc_id_t sel_o,
    output logic    take_o,
    output exc_id_t id_o
);
    ctl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        go_o    = 1'b0;
        sel_o   = win_i;
        unique case (state_q)
            ST_BOOT: begin
                go_o    = 1'b1;
                sel_o   = EXC_RST;
                state_d = ST_HOLD;
            end
            ST_RUN: begin
                if (hit_i && (ready_i || win_i == EXC_RST)) begin
                    go_o    = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_o <= 1'b0;
            id_o   <= EXC_RST;
        end else begin
            take_o <= go_o;
            if (go_o) id_o <= sel_o;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rst,
    input  logic              req_dabt,
    input  logic              fiq_async,
    input  logic              irq_async,
    input  logic              req_pabt,
    input  logic              req_swi,
    input  logic              mask_f_in,
    input  logic              mask_i_in,
    input  logic              pipe_ready,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              take_o,
    output logic [2:0]        exc_id_o,
    output logic [1:0]        mode_o,
    output logic [3:0]        ret_adj_o,
    output logic [ADDR_W-1:0] link_o,
    output logic              mask_f_o,
    output logic              mask_i_o
);
    logic [1:0]       irq_sync;
    logic [N_EXC-1:0] req_vec;
    logic             hit, go;
    exc_id_t          win, sel, id_q;

    exc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({irq_async, fiq_async}),
        .q_o   (irq_sync)
    );

    always_comb begin
        req_vec           = '0;
        req_vec[EXC_RST]  = req_rst;
        req_vec[EXC_DABT] = req_dabt;
        req_vec[EXC_FIQ]  = irq_sync[0] & ~mask_f_in;
        req_vec[EXC_IRQ]  = irq_sync[1] & ~mask_i_in;
        req_vec[EXC_PABT] = req_pabt;
        req_vec[EXC_SWI]  = req_swi;
    end

    exc_prio #(.N(N_EXC)) u_prio (
        .req_i (req_vec),
        .hit_o (hit),
        .win_o (win)
    );

    exc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .win_i   (win),
        .ready_i (pipe_ready),
        .go_o    (go),
        .sel_o   (sel),
        .take_o  (take_o),
        .id_o    (id_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o    <= MODE_SVC;
            ret_adj_o <= '0;
            link_o    <= '0;
            mask_f_o  <= 1'b1;
            mask_i_o  <= 1'b1;
        end else if (go) begin
            mode_o    <= mode_of(sel);
            ret_adj_o <= adj_of(sel);
            link_o    <= cur_pc;
            mask_i_o  <= 1'b1;
            mask_f_o  <= (sel == EXC_RST || sel == EXC_FIQ) ? 1'b1 : mask_f_in;
        end else begin
            mask_f_o  <= mask_f_in;
            mask_i_o  <= mask_i_in;
        end
    end

    assign exc_id_o = id_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_ready,
    input logic              mask_i_in,
    input logic              mask_f_in,
    input logic [ADDR_W-1:0] cur_pc,
    input logic              take_o,
    input logic [2:0]        exc_id_o,
    input logic [1:0]        mode_o,
    input logic [3:0]        ret_adj_o,
    input logic [ADDR_W-1:0] link_o,
    input logic              mask_f_o,
    input logic              mask_i_o
);
    p_id_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> exc_id_o <= 3'd5);

    p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_id_o != 3'd0) |-> $past(pipe_ready));

    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_id_o == 3'd3) |-> !$past(mask_i_in));

    p_fiq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_id_o == 3'd2) |-> !$past(mask_f_in));

    p_fiq_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_id_o == 3'd2) |-> (mask_f_o && mask_i_o));

    p_swi_adj_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_id_o == 3'd5) |-> ret_adj_o == 4'd0);

    p_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_id_o != 3'd0) |-> link_o == $past(cur_pc));

    p_irq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && exc_id_o == 3'd3) |-> mode_o == 2'd3);

    p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_ready (pipe_ready),
    .mask_i_in  (mask_i_in),
    .mask_f_in  (mask_f_in),
    .cur_pc     (cur_pc),
    .take_o     (take_o),
    .exc_id_o   (exc_id_o),
    .mode_o     (mode_o),
    .ret_adj_o  (ret_adj_o),
    .link_o     (link_o),
    .mask_f_o   (mask_f_o),
    .mask_i_o   (mask_i_o)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rst = 0, req_dabt = 0, fiq_async = 0, irq_async = 0;
    logic req_pabt = 0, req_swi = 0, mask_f_in = 0, mask_i_in = 0;
    logic pipe_ready = 1;
    logic [31:0] cur_pc = 32'h0;
    logic take_o, mask_f_o, mask_i_o;
    logic [2:0] exc_id_o;
    logic [1:0] mode_o;
    logic [3:0] ret_adj_o;
    logic [31:0] link_o;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_rst(req_rst), .req_dabt(req_dabt),
        .fiq_async(fiq_async), .irq_async(irq_async), .req_pabt(req_pabt),
        .req_swi(req_swi), .mask_f_in(mask_f_in), .mask_i_in(mask_i_in),
        .pipe_ready(pipe_ready), .cur_pc(cur_pc), .take_o(take_o),
        .exc_id_o(exc_id_o), .mode_o(mode_o), .ret_adj_o(ret_adj_o),
        .link_o(link_o), .mask_f_o(mask_f_o), .mask_i_o(mask_i_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_mode(int id);
        case (id)
            1, 4: return 2'd1;
            2:    return 2'd2;
            3:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [3:0] exp_adj(int id);
        case (id)
            2, 3, 4: return 4'd4;
            1:       return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    // full entry check; fmask is mask_f_in of the decision cycle
    task automatic expect_take(string tag, int id, logic [31:0] pc, logic fmask);
        chk({tag, " R1 take"}, take_o, 1);
        chk({tag, " R1 id"}, exc_id_o, id);
        chk({tag, " R9 mode"}, mode_o, exp_mode(id));
        chk({tag, " R7 adj"}, ret_adj_o, exp_adj(id));
        if (id != 0) chk({tag, " R8 link"}, link_o, pc);
        chk({tag, " R6 mask_i"}, mask_i_o, 1);
        chk({tag, " R6 mask_f"}, mask_f_o, (id == 0 || id == 2) ? 1'b1 : fmask);
    endtask

    task automatic settle_async();
        mask_f_in = 1; mask_i_in = 1; fiq_async = 0; irq_async = 0;
        repeat (4) step();
        mask_f_in = 0; mask_i_in = 0;
        step();
    endtask

    task automatic t_boot();
        step();
        chk("R2 boot take", take_o, 1);
        chk("R2 boot id", exc_id_o, 0);
        chk("R2 boot mask_f", mask_f_o, 1);
        chk("R2 boot mask_i", mask_i_o, 1);
        step();
        chk("R11 gap after boot", take_o, 0);
        step();
    endtask

    task automatic t_single(int id);
        cur_pc = 32'h1000 + id * 32'h10;
        case (id)
            1: req_dabt = 1;
            4: req_pabt = 1;
            default: req_swi = 1;
        endcase
        step();
        expect_take($sformatf("single%0d", id), id, 32'h1000 + id * 32'h10, 0);
        req_dabt = 0; req_pabt = 0; req_swi = 0;
        step();
        chk("R11 gap", take_o, 0);
        step();
    endtask

    task automatic t_sync_prio();
        req_dabt = 1; req_pabt = 1; req_swi = 1; cur_pc = 32'h2000;
        step();
        expect_take("prio_dabt", 1, 32'h2000, 0);
        req_dabt = 0; cur_pc = 32'h2004;
        step();
        chk("R11 gap prio", take_o, 0);
        step();
        expect_take("prio_pabt", 4, 32'h2004, 0);
        req_pabt = 0; cur_pc = 32'h2008;
        step();
        step();
        expect_take("prio_swi", 5, 32'h2008, 0);
        req_swi = 0;
        step();
        step();
    endtask

    task automatic t_ready_gate();
        pipe_ready = 0; req_swi = 1; cur_pc = 32'h3000;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4 no take while not ready", take_o, 0);
        end
        pipe_ready = 1;
        step();
        expect_take("R4 ready", 5, 32'h3000, 0);
        req_swi = 0;
        step();
        step();
    endtask

    task automatic t_rst_noready();
        pipe_ready = 0; req_rst = 1; req_swi = 1; mask_f_in = 0; mask_i_in = 0;
        step();
        chk("R3 rst take", take_o, 1);
        chk("R3 rst id", exc_id_o, 0);
        chk("R3 rst mask_f", mask_f_o, 1);
        chk("R3 rst mask_i", mask_i_o, 1);
        req_rst = 0; req_swi = 0; pipe_ready = 1;
        step();
        step();
    endtask

    task automatic t_fiq_latency();
        cur_pc = 32'h4000; fiq_async = 1;
        step();
        chk("R10 edge1 no take", take_o, 0);
        step();
        chk("R10 edge2 no take", take_o, 0);
        step();
        expect_take("R10 fiq", 2, 32'h4000, 0);
        settle_async();
    endtask

    task automatic t_irq_mask();
        mask_i_in = 1; irq_async = 1; cur_pc = 32'h5000;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R5 irq masked", take_o, 0);
        end
        mask_i_in = 0;
        step();
        expect_take("R5 irq unmasked", 3, 32'h5000, 0);
        settle_async();
        mask_f_in = 1; fiq_async = 1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R5 fiq masked", take_o, 0);
        end
        settle_async();
    endtask

    task automatic t_same_cycle();
        pipe_ready = 0; fiq_async = 1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4 fiq held off", take_o, 0);
        end
        req_dabt = 1; pipe_ready = 1; cur_pc = 32'h6000;
        step();
        expect_take("R1 dabt over fiq", 1, 32'h6000, 0);
        req_dabt = 0; cur_pc = 32'h6004;
        step();
        chk("R11 gap same", take_o, 0);
        step();
        expect_take("R1 fiq after dabt", 2, 32'h6004, 0);
        settle_async();
    endtask

    task automatic t_mask_pass();
        mask_f_in = 1; mask_i_in = 0;
        step();
        chk("R12 mask_f pass", mask_f_o, 1);
        chk("R12 mask_i pass", mask_i_o, 0);
        mask_f_in = 0; mask_i_in = 1;
        step();
        chk("R12 mask_f pass2", mask_f_o, 0);
        chk("R12 mask_i pass2", mask_i_o, 1);
        mask_i_in = 0;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset take low", take_o, 0);
        chk("R2 reset masks", {mask_f_o, mask_i_o}, 2'b11);
        rst_n = 1;
        t_boot();
        t_single(1);
        t_single(4);
        t_single(5);
        t_sync_prio();
        t_ready_gate();
        t_rst_noready();
        t_fiq_latency();
        t_irq_mask();
        t_same_cycle();
        t_mask_pass();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule